// File: doc/BRIEF.md
# Page Access Frequency Ranker

This block sits next to a memory controller and ranks recently used memory pages by how often they are touched. Each access the controller makes is posted as a page number into a small update queue. The ranking engine works through that queue in the background, so the request path never waits on it. A bounded table of descriptors records, for each tracked page, its page number, a reference count, an expiry stamp, a last-touch stamp and a frequency level. Level 0 is the least frequent level and level `LEVELS-1` is the most frequent.

Pages climb one level each time their reference count reaches a threshold that doubles with every level. Pages that go untouched for `TIMEOUT` processed accesses fall one level, and at level 0 they leave the table. Ageing counts accesses, not time. Within a level, recency is given by the last-touch stamp. When the table is full, a new page takes the place of the least recently touched level-0 page. At each epoch boundary, software walks the table through a combinational read port and picks out the pages of each level.

Top module: `page_freq_tracker`

## Requirements
- R1: After reset, no table entry is valid, and both the processed-access counter and the dropped-update counter read 0.
- R2: A page that is not in the table is placed in the lowest-numbered free entry with level 0 and reference count 1.
- R3: The processed-access counter grows by exactly one for every update taken from the queue, including an update whose page cannot be placed in the table. It holds its value otherwise.
- R4: Each access to a tracked page adds one to its reference count. When the count reaches 2^(L+1) at level L, the page moves to level L+1 and its count returns to 0.
- R5: Level `LEVELS-1` is the ceiling. Further accesses at that level raise the reference count, saturating at its maximum, and the level never goes above `LEVELS-1`.
- R6: A page at level L>0 that receives no access while `TIMEOUT` updates are processed drops to level L-1 with reference count 0. Its expiry restarts from that point.
- R7: A level-0 page that receives no access while `TIMEOUT` updates are processed is removed from the table.
- R8: When the table is full, a new page replaces the level-0 entry with the oldest last touch. Entries above level 0 are never replaced.
- R9: When the table is full and holds no level-0 entry, a new page is not tracked and every existing entry is left as it was.
- R10: The engine takes one update every two clock cycles, in arrival order. If a page arrives while the queue is full and nothing leaves it in that cycle, the oldest queued update is discarded and the dropped-update counter grows by one.
- R11: The read port returns the valid flag, page, level and reference count of entry `rd_idx_i`. `rd_match_o` is high only when that entry is valid and its level equals `rd_level_i`.
- R12: No two valid entries ever hold the same page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Posts one page access into the update queue |
| acc_page_i | input | PAGE_W | Page number of the posted access |
| rd_idx_i | input | IDX_W | Table entry selected for reading |
| rd_level_i | input | LVL_W | Level compared against the selected entry |
| rd_valid_o | output | 1 | Selected entry holds a page |
| rd_page_o | output | PAGE_W | Page number of the selected entry |
| rd_level_o | output | LVL_W | Level of the selected entry |
| rd_refs_o | output | REF_W | Reference count of the selected entry |
| rd_match_o | output | 1 | Selected entry is valid and at level `rd_level_i` |
| access_cnt_o | output | CNT_W | Running count of processed updates |
| drop_cnt_o | output | CNT_W | Count of updates discarded by the queue |

## Verification
The uniqueness and single-hit assertions assume that every page enters the table only through the miss path. They therefore depend on the engine looking up an update only after the previous update has been written back. The bench never relies on anything more than that, and it usually leaves three cycles between posted pages, so each update is processed on its own. The one exception is the overflow scenario, which posts a page every cycle on purpose. The step assertions on the two counters assume the counters do not wrap, and the bench stays far below `2^CNT_W` accesses.

// File: rtl/page_trk_pkg.sv
package page_trk_pkg;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_UPD  = 1'b1
  } eng_state_e;

  function automatic int unsigned width_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/page_trk_fifo.sv
module page_trk_fifo #(
  parameter int DATA_W = 20,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic              empty_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  drop_cnt_o
);
  localparam int PTR_W = page_trk_pkg::width_of(DEPTH);
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [OCC_W-1:0]  occ_q;
  logic [CNT_W-1:0]  drop_q;
  logic              full, do_pop, drop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (occ_q == FULL);
  assign empty_o = (occ_q == '0);
  assign do_pop  = pop_i && !empty_o;
  // overwrite-oldest when full and nothing leaves this cycle
  assign drop    = push_i && full && !do_pop;
  assign data_o  = mem_q[rd_q];
  assign drop_cnt_o = drop_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      occ_q  <= '0;
      drop_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (do_pop || drop) rd_q <= nxt(rd_q);
      if (push_i && !do_pop && !full) occ_q <= occ_q + 1'b1;
      else if (!push_i && do_pop)     occ_q <= occ_q - 1'b1;
      if (drop) drop_q <= drop_q + 1'b1;
    end
  end
endmodule

// File: rtl/page_trk_slot.sv
module page_trk_slot #(
  parameter int PAGE_W  = 20,
  parameter int LEVELS  = 4,
  parameter int LVL_W   = 2,
  parameter int REF_W   = 5,
  parameter int CNT_W   = 16,
  parameter int TIMEOUT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              hit_i,
  input  logic              alloc_i,
  input  logic [CNT_W-1:0]  cnt_n_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              valid_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [LVL_W-1:0]  level_o,
  output logic [REF_W-1:0]  refs_o,
  output logic [CNT_W-1:0]  stamp_o
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);
  localparam logic [REF_W-1:0] REF_MAX = '1;
  localparam logic [CNT_W-1:0] TMO     = CNT_W'(TIMEOUT);

  logic              valid_q, valid_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [LVL_W-1:0]  level_q, level_d;
  logic [REF_W-1:0]  refs_q, refs_d, refs_inc;
  logic [CNT_W-1:0]  exp_q, exp_d, stamp_q, stamp_d;
  logic [REF_W:0]    thr;
  logic              promote, expired;

  always_comb begin
    refs_inc = (refs_q == REF_MAX) ? refs_q : refs_q + 1'b1;
    thr      = (REF_W+1)'(1) << ({1'b0, level_q} + 1'b1);
    promote  = (level_q != TOP_LVL) && ({1'b0, refs_inc} >= thr);
    expired  = valid_q && (exp_q == cnt_n_i);

    valid_d = valid_q;
    page_d  = page_q;
    level_d = level_q;
    refs_d  = refs_q;
    exp_d   = exp_q;
    stamp_d = stamp_q;

    if (tick_i) begin
      if (alloc_i) begin
        valid_d = 1'b1;
        page_d  = page_i;
        level_d = '0;
        refs_d  = REF_W'(1);
        exp_d   = cnt_n_i + TMO;
        stamp_d = cnt_n_i;
      end else if (hit_i) begin
        exp_d   = cnt_n_i + TMO;
        stamp_d = cnt_n_i;
        if (promote) begin
          level_d = level_q + 1'b1;
          refs_d  = '0;
        end else begin
          refs_d  = refs_inc;
        end
      end else if (expired) begin
        exp_d  = cnt_n_i + TMO;
        refs_d = '0;
        if (level_q == '0) valid_d = 1'b0;
        else               level_d = level_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      page_q  <= '0;
      level_q <= '0;
      refs_q  <= '0;
      exp_q   <= '0;
      stamp_q <= '0;
    end else begin
      valid_q <= valid_d;
      page_q  <= page_d;
      level_q <= level_d;
      refs_q  <= refs_d;
      exp_q   <= exp_d;
      stamp_q <= stamp_d;
    end
  end

  assign valid_o = valid_q;
  assign page_o  = page_q;
  assign level_o = level_q;
  assign refs_o  = refs_q;
  assign stamp_o = stamp_q;
endmodule

// File: rtl/page_trk_pick.sv
module page_trk_pick #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3,
  parameter int LVL_W   = 2,
  parameter int CNT_W   = 16
) (
  input  logic               valid_i [ENTRIES],
  input  logic [LVL_W-1:0]   level_i [ENTRIES],
  input  logic [CNT_W-1:0]   stamp_i [ENTRIES],
  input  logic [CNT_W-1:0]   now_i,
  output logic [ENTRIES-1:0] sel_o
);
  logic             free_found, lru_ok;
  logic [CNT_W-1:0] best_age, age;
  logic [IDX_W-1:0] best_idx;

  always_comb begin
    sel_o      = '0;
    free_found = 1'b0;
    lru_ok     = 1'b0;
    best_age   = '0;
    best_idx   = '0;
    age        = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!valid_i[e] && !free_found) begin
        sel_o[e]   = 1'b1;
        free_found = 1'b1;
      end
    end
    if (!free_found) begin
      // oldest last-touch among level-0 entries; lowest index wins ties
      for (int e = 0; e < ENTRIES; e++) begin
        age = now_i - stamp_i[e];
        if (level_i[e] == '0 && (!lru_ok || age > best_age)) begin
          lru_ok   = 1'b1;
          best_age = age;
          best_idx = IDX_W'(e);
        end
      end
      if (lru_ok) sel_o[best_idx] = 1'b1;
    end
  end
endmodule

// File: rtl/page_freq_tracker.sv
module page_freq_tracker #(
  parameter int PAGE_W     = 20,
  parameter int ENTRIES    = 8,
  parameter int LEVELS     = 4,
  parameter int TIMEOUT    = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16,
  localparam int IDX_W     = page_trk_pkg::width_of(ENTRIES),
  localparam int LVL_W     = page_trk_pkg::width_of(LEVELS),
  localparam int REF_W     = LEVELS + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [PAGE_W-1:0] acc_page_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [LVL_W-1:0]  rd_level_i,
  output logic              rd_valid_o,
  output logic [PAGE_W-1:0] rd_page_o,
  output logic [LVL_W-1:0]  rd_level_o,
  output logic [REF_W-1:0]  rd_refs_o,
  output logic              rd_match_o,
  output logic [CNT_W-1:0]  access_cnt_o,
  output logic [CNT_W-1:0]  drop_cnt_o
);
  import page_trk_pkg::*;

  eng_state_e        state_q;
  logic              q_empty, pop, tick, any_hit;
  logic [PAGE_W-1:0] q_page, hold_page_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ENTRIES-1:0] hit_vec, pick_vec, alloc_vec;

  logic              slot_valid [ENTRIES];
  logic [PAGE_W-1:0] slot_page  [ENTRIES];
  logic [LVL_W-1:0]  slot_level [ENTRIES];
  logic [REF_W-1:0]  slot_refs  [ENTRIES];
  logic [CNT_W-1:0]  slot_stamp [ENTRIES];

  page_trk_fifo #(
    .DATA_W(PAGE_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
  ) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (acc_valid_i),
    .data_i     (acc_page_i),
    .pop_i      (pop),
    .empty_o    (q_empty),
    .data_o     (q_page),
    .drop_cnt_o (drop_cnt_o)
  );

  // two-phase engine: capture, then look up and write back
  assign pop  = (state_q == ENG_IDLE) && !q_empty;
  assign tick = (state_q == ENG_UPD);
  assign cnt_n = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ENG_IDLE;
      hold_page_q <= '0;
      cnt_q       <= '0;
    end else begin
      state_q <= pop ? ENG_UPD : ENG_IDLE;
      if (pop)  hold_page_q <= q_page;
      if (tick) cnt_q <= cnt_n;
    end
  end

  assign any_hit   = |hit_vec;
  assign alloc_vec = (tick && !any_hit) ? pick_vec : '0;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    assign hit_vec[e] = slot_valid[e] && (slot_page[e] == hold_page_q);

    page_trk_slot #(
      .PAGE_W(PAGE_W), .LEVELS(LEVELS), .LVL_W(LVL_W),
      .REF_W(REF_W), .CNT_W(CNT_W), .TIMEOUT(TIMEOUT)
    ) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .hit_i   (hit_vec[e]),
      .alloc_i (alloc_vec[e]),
      .cnt_n_i (cnt_n),
      .page_i  (hold_page_q),
      .valid_o (slot_valid[e]),
      .page_o  (slot_page[e]),
      .level_o (slot_level[e]),
      .refs_o  (slot_refs[e]),
      .stamp_o (slot_stamp[e])
    );
  end

  page_trk_pick #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .LVL_W(LVL_W), .CNT_W(CNT_W)
  ) u_pick (
    .valid_i (slot_valid),
    .level_i (slot_level),
    .stamp_i (slot_stamp),
    .now_i   (cnt_n),
    .sel_o   (pick_vec)
  );

  always_comb begin
    rd_valid_o = 1'b0;
    rd_page_o  = '0;
    rd_level_o = '0;
    rd_refs_o  = '0;
    if (int'(rd_idx_i) < ENTRIES) begin
      rd_valid_o = slot_valid[rd_idx_i];
      rd_page_o  = slot_page[rd_idx_i];
      rd_level_o = slot_level[rd_idx_i];
      rd_refs_o  = slot_refs[rd_idx_i];
    end
  end

  assign rd_match_o   = rd_valid_o && (rd_level_o == rd_level_i);
  assign access_cnt_o = cnt_q;
endmodule

// File: rtl/page_trk_checker.sv
module page_trk_checker #(
  parameter int PAGE_W  = 20,
  parameter int ENTRIES = 8,
  parameter int LEVELS  = 4,
  parameter int LVL_W   = 2,
  parameter int CNT_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic [ENTRIES-1:0] hit_vec_i,
  input logic [ENTRIES-1:0] alloc_vec_i,
  input logic               valid_i [ENTRIES],
  input logic [PAGE_W-1:0]  page_i  [ENTRIES],
  input logic [LVL_W-1:0]   level_i [ENTRIES],
  input logic [CNT_W-1:0]   access_cnt_i,
  input logic [CNT_W-1:0]   drop_cnt_i
);
  assert_one_hit_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_i));

  assert_one_alloc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(alloc_vec_i));

  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> access_cnt_i == $past(access_cnt_i) + 1'b1);

  assert_cnt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(access_cnt_i));

  assert_tick_spacing_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  assert_drop_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (drop_cnt_i == $past(drop_cnt_i)) ||
             (drop_cnt_i == $past(drop_cnt_i) + 1'b1));

  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int a = 0; a < ENTRIES; a++) begin
        if (valid_i[a]) begin
          assert_level_range_R5: assert (int'(level_i[a]) < LEVELS);
        end
        if (alloc_vec_i[a] && valid_i[a]) begin
          assert_victim_level0_R8: assert (level_i[a] == '0);
        end
        for (int b = a + 1; b < ENTRIES; b++) begin
          if (valid_i[a] && valid_i[b]) begin
            assert_unique_page_R12: assert (page_i[a] != page_i[b]);
          end
        end
      end
    end
  end
endmodule

bind page_freq_tracker page_trk_checker #(
  .PAGE_W(PAGE_W), .ENTRIES(ENTRIES), .LEVELS(LEVELS),
  .LVL_W(LVL_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick),
  .hit_vec_i    (hit_vec),
  .alloc_vec_i  (alloc_vec),
  .valid_i      (slot_valid),
  .page_i       (slot_page),
  .level_i      (slot_level),
  .access_cnt_i (access_cnt_o),
  .drop_cnt_i   (drop_cnt_o)
);

// File: tb/page_freq_tracker_bench.sv
module page_freq_tracker_bench;
  localparam int PAGE_W  = 20;
  localparam int ENTRIES = 8;
  localparam int LEVELS  = 4;
  localparam int TIMEOUT = 16;
  localparam int IDX_W   = 3;
  localparam int LVL_W   = 2;
  localparam int REF_W   = 5;
  localparam int CNT_W   = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              acc_valid_i = 1'b0;
  logic [PAGE_W-1:0] acc_page_i = '0;
  logic [IDX_W-1:0]  rd_idx_i = '0;
  logic [LVL_W-1:0]  rd_level_i = '0;
  logic              rd_valid_o, rd_match_o;
  logic [PAGE_W-1:0] rd_page_o;
  logic [LVL_W-1:0]  rd_level_o;
  logic [REF_W-1:0]  rd_refs_o;
  logic [CNT_W-1:0]  access_cnt_o, drop_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  page_freq_tracker #(
    .PAGE_W(PAGE_W), .ENTRIES(ENTRIES), .LEVELS(LEVELS),
    .TIMEOUT(TIMEOUT), .FIFO_DEPTH(4), .CNT_W(CNT_W)
  ) u_page_freq_tracker (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .acc_valid_i(acc_valid_i), .acc_page_i(acc_page_i),
    .rd_idx_i(rd_idx_i), .rd_level_i(rd_level_i),
    .rd_valid_o(rd_valid_o), .rd_page_o(rd_page_o),
    .rd_level_o(rd_level_o), .rd_refs_o(rd_refs_o),
    .rd_match_o(rd_match_o),
    .access_cnt_o(access_cnt_o), .drop_cnt_o(drop_cnt_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    acc_valid_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // posted at a falling edge; captured, taken and written back by the third rising edge
  task automatic access(input int pg);
    @(negedge clk_i);
    acc_valid_i = 1'b1;
    acc_page_i  = PAGE_W'(pg);
    @(negedge clk_i);
    acc_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic access_n(input int pg, input int n);
    for (int k = 0; k < n; k++) access(pg);
  endtask

  task automatic find(input int pg, output bit found, output int idx,
                      output int lvl, output int refs);
    found = 1'b0; idx = -1; lvl = -1; refs = -1;
    for (int i = 0; i < ENTRIES; i++) begin
      rd_idx_i = IDX_W'(i);
      #1;
      if (!found && rd_valid_o && rd_page_o == PAGE_W'(pg)) begin
        found = 1'b1; idx = i; lvl = int'(rd_level_o); refs = int'(rd_refs_o);
      end
    end
  endtask

  task automatic t_reset();
    int nvalid;
    do_reset();
    nvalid = 0;
    for (int i = 0; i < ENTRIES; i++) begin
      rd_idx_i = IDX_W'(i);
      #1;
      if (rd_valid_o) nvalid++;
    end
    chk("R1 valid entries after reset", nvalid, 0);
    chk("R1 access count after reset", int'(access_cnt_o), 0);
    chk("R1 drop count after reset", int'(drop_cnt_o), 0);
  endtask

  task automatic t_promote();
    bit f; int idx, lvl, refs;
    do_reset();
    access(32'h55);
    find(32'h55, f, idx, lvl, refs);
    chk("R2 new page slot", idx, 0);
    chk("R2 new page level", lvl, 0);
    chk("R2 new page refs", refs, 1);
    access(32'h55);
    find(32'h55, f, idx, lvl, refs);
    chk("R4 promote to level 1", lvl, 1);
    chk("R4 refs cleared on promote", refs, 0);
    access_n(32'h55, 3);
    find(32'h55, f, idx, lvl, refs);
    chk("R4 below threshold level", lvl, 1);
    chk("R4 below threshold refs", refs, 3);
    access(32'h55);
    find(32'h55, f, idx, lvl, refs);
    chk("R4 promote to level 2", lvl, 2);
    access_n(32'h55, 8);
    find(32'h55, f, idx, lvl, refs);
    chk("R4 promote to level 3", lvl, 3);
    access_n(32'h55, 2);
    find(32'h55, f, idx, lvl, refs);
    chk("R5 top level holds", lvl, 3);
    chk("R5 top level refs count", refs, 2);
    chk("R3 access count", int'(access_cnt_o), 16);
  endtask

  task automatic t_expire();
    bit f; int idx, lvl, refs;
    do_reset();
    access_n(32'hA0, 2);
    access_n(32'hB0, TIMEOUT - 1);
    find(32'hA0, f, idx, lvl, refs);
    chk("R6 level kept before timeout", lvl, 1);
    access(32'hB0);
    find(32'hA0, f, idx, lvl, refs);
    chk("R6 demoted one level", lvl, 0);
    chk("R6 refs cleared on demote", refs, 0);
    // R11 level query on the two tracked pages
    rd_idx_i = IDX_W'(idx); rd_level_i = 2'd0; #1;
    chk("R11 match at level 0", int'(rd_match_o), 1);
    find(32'hB0, f, idx, lvl, refs);
    rd_idx_i = IDX_W'(idx); rd_level_i = 2'd3; #1;
    chk("R11 match at level 3", int'(rd_match_o), 1);
    chk("R11 read page", int'(rd_page_o), 32'hB0);
    rd_level_i = 2'd2; #1;
    chk("R11 no match at other level", int'(rd_match_o), 0);
    access_n(32'hB0, TIMEOUT - 1);
    find(32'hA0, f, idx, lvl, refs);
    chk("R7 level-0 page kept before timeout", int'(f), 1);
    access(32'hB0);
    find(32'hA0, f, idx, lvl, refs);
    chk("R7 level-0 page removed", int'(f), 0);
  endtask

  task automatic t_evict();
    bit f; int idx, lvl, refs;
    do_reset();
    for (int p = 0; p < ENTRIES; p++) access(100 + p);
    access(100);
    access(200);
    find(200, f, idx, lvl, refs);
    chk("R8 new page takes LRU level-0 slot", idx, 1);
    chk("R8 new page level", lvl, 0);
    find(101, f, idx, lvl, refs);
    chk("R8 victim removed", int'(f), 0);
    find(100, f, idx, lvl, refs);
    chk("R8 level-1 entry kept", lvl, 1);
  endtask

  task automatic t_no_victim();
    bit f; int idx, lvl, refs, kept;
    do_reset();
    for (int p = 0; p < ENTRIES; p++) access_n(300 + p, 2);
    access(400);
    find(400, f, idx, lvl, refs);
    chk("R9 new page not tracked", int'(f), 0);
    kept = 0;
    for (int p = 0; p < ENTRIES; p++) begin
      find(300 + p, f, idx, lvl, refs);
      if (f && idx == p && lvl == 1) kept++;
    end
    chk("R9 existing entries unchanged", kept, ENTRIES);
    chk("R3 untracked access still counted", int'(access_cnt_o), 2 * ENTRIES + 1);
  endtask

  task automatic t_fifo_drop();
    bit f; int idx, lvl, refs;
    do_reset();
    for (int k = 0; k < 12; k++) begin
      @(negedge clk_i);
      acc_valid_i = 1'b1;
      acc_page_i  = PAGE_W'(500 + k);
    end
    @(negedge clk_i);
    acc_valid_i = 1'b0;
    repeat (20) @(negedge clk_i);
    chk("R10 drop count after burst", int'(drop_cnt_o), 2);
    chk("R10 processed updates", int'(access_cnt_o), 10);
    find(504, f, idx, lvl, refs);
    chk("R10 first dropped page absent", int'(f), 0);
    find(506, f, idx, lvl, refs);
    chk("R10 second dropped page absent", int'(f), 0);
    find(511, f, idx, lvl, refs);
    chk("R10 last page processed", int'(f), 1);
  endtask

  initial begin
    t_reset();
    t_promote();
    t_expire();
    t_evict();
    t_no_victim();
    t_fifo_drop();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule